// File: doc/BRIEF.md
# Overcurrent Trip Latch with Fault-Clear Timer

This block turns a digitized overcurrent comparator signal into a gate-shutdown command. A digital filter rejects glitches shorter than a set number of clock cycles. A qualified trip then sets a set-dominant fault latch, and that latch forces the gate outputs off. Two counters take the place of an external timing capacitor. The drain counter runs while the filtered trip is present. The refill counter sets the fault-clear time after a long trip. If a trip is too short to drain the timing element below its low threshold, the latch releases as soon as the trip clears. The outputs then restart at once, which acts as a cycle-by-cycle soft current limit.

An active-low fault flag reports either a latched overcurrent or an external undervoltage condition. The flag is delayed by a fixed number of cycles. All timing is given as parameters in clock cycles. The fault-clear time is a base cycle count scaled linearly by a capacitance factor written in tenths.

Top module: `otg_trip_guard`

## Requirements
- R1: The filtered trip changes state only after `trip_raw` has held its new value for FILT_CYC consecutive clock edges. A `trip_raw` high pulse shorter than FILT_CYC cycles leaves `fault_latched`, `recovering` and `fault_n` unchanged.
- R2: When `trip_raw` rises before clock edge 1 and stays high for H >= FILT_CYC edges, `fault_latched` is 1 from the cycle after edge FILT_CYC+1. It stays 1 without interruption while the filtered trip is present.
- R3: If H < DRAIN_CYC, `fault_latched` is 1 up to and including the cycle after edge H+FILT_CYC, and 0 after that. `recovering` never goes high.
- R4: If H >= DRAIN_CYC, `recovering` is 1 for exactly CLR_CYC cycles, from edge H+FILT_CYC+1 to edge H+FILT_CYC+CLR_CYC. `fault_latched` stays 1 through edge H+FILT_CYC+CLR_CYC and then clears.
- R5: CLR_CYC equals floor(CLR_BASE_CYC * CAP_X10 / 10).
- R6: A filtered trip that arrives while `recovering` is 1 drops `recovering` and discards the refill progress. Once that trip clears, a full CLR_CYC refill follows, even if the new trip lasted fewer than DRAIN_CYC cycles.
- R7: `fault_n` is 0 in the cycle after edge k exactly when `fault_latched` was 1 after edge k-FLAG_DLY, or when `uv_fault` was 1 at edge k-FLAG_DLY+1.
- R8: `uv_fault` alone drives `fault_n` low and never sets `fault_latched` or `recovering`.
- R9: After reset, `fault_latched` and `recovering` are 0 and `fault_n` is 1. The timing element counts as fully charged, so the first short trip releases at once as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_raw | input | 1 | Digitized overcurrent comparator output, active high |
| uv_fault | input | 1 | Undervoltage condition, active high |
| fault_latched | output | 1 | Latched overcurrent; gate outputs must be held off while 1 |
| fault_n | output | 1 | Delayed active-low fault flag |
| recovering | output | 1 | High while the fault-clear refill is running |

## Verification
The bench builds the block with FILT_CYC=3, DRAIN_CYC=5, CLR_BASE_CYC=4, CAP_X10=25 (so CLR_CYC=10) and FLAG_DLY=2. With these values every trip length from 1 to 12 cycles fits in a short run. That range covers a rejected glitch, the immediate-restart band and the full-recovery band. Checking every cycle exposes each edge of the latch, the refill window and the delayed flag. A retrigger placed inside the refill window and a sweep of undervoltage pulses complete the set.

// File: rtl/otg_pkg.sv
package otg_pkg;

  typedef enum logic [1:0] {
    TM_IDLE   = 2'd0,
    TM_DRAIN  = 2'd1,
    TM_REFILL = 2'd2
  } tmr_state_e;

  // Fault-clear time scaled linearly by a capacitance factor in tenths.
  function automatic int unsigned scaled_clear(input int unsigned base_cyc,
                                               input int unsigned cap_x10);
    return (base_cyc * cap_x10) / 10;
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/otg_filter.sv
module otg_filter #(
  parameter int unsigned FILT_CYC = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = otg_pkg::cnt_width(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      dout  <= 1'b0;
    end else if (din == dout) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q <= '0;
      dout  <= din;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/otg_rc_timer.sv
module otg_rc_timer
  import otg_pkg::*;
#(
  parameter int unsigned DRAIN_CYC = 64,
  parameter int unsigned CLR_CYC   = 95000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_f,
  output logic       latch_q,
  output logic       deep_q,
  output logic       release_ev,
  output tmr_state_e state_q
);
  localparam int unsigned DW = cnt_width(DRAIN_CYC);
  localparam int unsigned RW = cnt_width(CLR_CYC);
  localparam logic [DW-1:0] D_LAST = DW'(DRAIN_CYC - 1);
  localparam logic [RW-1:0] R_LAST = RW'(CLR_CYC - 1);
  localparam logic          DEEP_AT_ENTRY = (DRAIN_CYC == 1);

  logic [DW-1:0] drain_q;
  logic [RW-1:0] fill_q;

  assign release_ev = !trip_f &&
                      (((state_q == TM_DRAIN) && !deep_q) ||
                       ((state_q == TM_REFILL) && (fill_q == R_LAST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      deep_q  <= 1'b0;
      drain_q <= '0;
      fill_q  <= '0;
      state_q <= TM_IDLE;
    end else begin
      // set-dominant latch
      latch_q <= trip_f | (latch_q & ~release_ev);
      unique case (state_q)
        TM_IDLE: begin
          if (trip_f) begin
            state_q <= TM_DRAIN;
            drain_q <= DW'(1);
            deep_q  <= DEEP_AT_ENTRY;
          end
        end
        TM_DRAIN: begin
          if (trip_f) begin
            if (!deep_q) begin
              if (drain_q == D_LAST) deep_q <= 1'b1;
              else                   drain_q <= drain_q + 1'b1;
            end
          end else if (deep_q) begin
            state_q <= TM_REFILL;
            fill_q  <= '0;
          end else begin
            state_q <= TM_IDLE;
          end
        end
        TM_REFILL: begin
          if (trip_f) begin
            state_q <= TM_DRAIN;
            drain_q <= DW'(1);
          end else if (fill_q == R_LAST) begin
            state_q <= TM_IDLE;
            deep_q  <= 1'b0;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
        end
        default: state_q <= TM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otg_flag_delay.sv
module otg_flag_delay #(
  parameter int unsigned DEPTH = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic flag_n
);
  generate
    if (DEPTH == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= src;
      end
      assign flag_n = ~stage_q;
    end else begin : g_chain
      logic [DEPTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[DEPTH-2:0], src};
      end
      assign flag_n = ~chain_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/otg_trip_guard.sv
module otg_trip_guard
  import otg_pkg::*;
#(
  parameter int unsigned FILT_CYC     = 11,
  parameter int unsigned DRAIN_CYC    = 64,
  parameter int unsigned CLR_BASE_CYC = 95000,
  parameter int unsigned CAP_X10      = 10,
  parameter int unsigned FLAG_DLY     = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw,
  input  logic uv_fault,
  output logic fault_latched,
  output logic fault_n,
  output logic recovering
);
  localparam int unsigned CLR_CYC = scaled_clear(CLR_BASE_CYC, CAP_X10);

  logic       trip_filt;
  logic       deep_ev;
  logic       release_ev;
  logic       flag_src;
  tmr_state_e tmr_state;

  otg_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(trip_raw), .dout(trip_filt)
  );

  otg_rc_timer #(.DRAIN_CYC(DRAIN_CYC), .CLR_CYC(CLR_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .trip_f(trip_filt), .latch_q(fault_latched),
    .deep_q(deep_ev), .release_ev(release_ev), .state_q(tmr_state)
  );

  assign recovering = (tmr_state == TM_REFILL);
  assign flag_src   = fault_latched | uv_fault;

  otg_flag_delay #(.DEPTH(FLAG_DLY)) u_flag (
    .clk(clk), .rst_n(rst_n), .src(flag_src), .flag_n(fault_n)
  );
endmodule

// File: rtl/otg_trip_guard_chk.sv
module otg_trip_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic trip_raw,
  input logic trip_filt,
  input logic deep_ev,
  input logic release_ev,
  input logic fault_latched,
  input logic recovering
);
  // R1
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_filt != $past(trip_filt)) |-> ($past(trip_raw) == trip_filt));

  // R2
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_filt |=> fault_latched);

  // R3
  shallow_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !trip_filt && !deep_ev && !recovering) |=> !fault_latched);

  // R4
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> fault_latched);

  // R6
  retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && trip_filt) |=> (!recovering && deep_ev && fault_latched));

  // R2
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_latched) |-> $past(release_ev && !trip_filt));
endmodule

bind otg_trip_guard otg_trip_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .trip_filt(trip_filt),
  .deep_ev(deep_ev), .release_ev(release_ev),
  .fault_latched(fault_latched), .recovering(recovering)
);

// File: tb/otg_trip_guard_bench.sv
module otg_trip_guard_bench;
  localparam int FILT = 3;
  localparam int DRN  = 5;
  localparam int BASE = 4;
  localparam int CX10 = 25;
  localparam int DLY  = 2;
  localparam int CLR  = (BASE * CX10) / 10;   // R5: 10 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_raw = 1'b0;
  logic uv_fault = 1'b0;
  logic fault_latched, fault_n, recovering;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  otg_trip_guard #(
    .FILT_CYC(FILT), .DRAIN_CYC(DRN), .CLR_BASE_CYC(BASE),
    .CAP_X10(CX10), .FLAG_DLY(DLY)
  ) u_otg_trip_guard (
    .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .uv_fault(uv_fault),
    .fault_latched(fault_latched), .fault_n(fault_n), .recovering(recovering)
  );

  task automatic chk(input logic got, input logic exp, input string req,
                     input string what, input int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, k, got, exp);
    end
  endtask

  function automatic bit in_rng(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // h: first trip length, g/h2: gap and second trip length (h2=0: none), ul: uv length
  task automatic run_case(input int h, input int g, input int h2, input int ul,
                          input string req);
    int a, b, r1lo, r1hi, r2lo, r2hi, n;
    bit on;
    a = 0; b = -1; r1lo = 0; r1hi = -1; r2lo = 0; r2hi = -1;
    on = (h >= FILT);
    if (on) begin
      a = FILT + 1;
      if (h2 > 0) begin
        r1lo = h + FILT + 1;
        r1hi = h + g + FILT;
        r2lo = h + g + h2 + FILT + 1;
        b    = h + g + h2 + FILT + CLR;
        r2hi = b;
      end else if (h >= DRN) begin
        b    = h + FILT + CLR;
        r1lo = h + FILT + 1;
        r1hi = b;
      end else begin
        b = h + FILT;
      end
    end
    n = h + g + h2 + ul + FILT + CLR + DLY + 6;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk(fault_latched, in_rng(k, a, b), req, "fault_latched", k);
        chk(recovering, in_rng(k, r1lo, r1hi) || in_rng(k, r2lo, r2hi), req, "recovering", k);
        chk(fault_n, !(in_rng(k - DLY, a, b) || (ul > 0 && in_rng(k, DLY, ul + DLY - 1))),
            "R7", "fault_n", k);
      end
      trip_raw = in_rng(k + 1, 1, h) || (h2 > 0 && in_rng(k + 1, h + g + 1, h + g + h2));
      uv_fault = (ul > 0) && in_rng(k + 1, 1, ul);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(fault_latched, 1'b0, "R9", "fault_latched after reset", 0);
    chk(recovering, 1'b0, "R9", "recovering after reset", 0);
    chk(fault_n, 1'b1, "R9", "fault_n after reset", 0);
    // R9: first trip is short, timer counts as charged -> immediate release
    run_case(3, 0, 0, 0, "R9");
    // R1 glitches, R3 short trips, R4 long trips
    for (int h = 1; h <= 12; h++) begin
      if (h < FILT)      run_case(h, 0, 0, 0, "R1");
      else if (h < DRN)  run_case(h, 0, 0, 0, "R3");
      else               run_case(h, 0, 0, 0, "R4");
    end
    // R5: refill length tied to the scaled clear count (long trip, full window)
    run_case(DRN, 0, 0, 0, "R5");
    // R6: short retrigger inside refill window
    for (int g = FILT; g <= 7; g++) run_case(6, g, 3, 0, "R6");
    // R8: undervoltage alone
    for (int ul = 1; ul <= 4; ul++) run_case(0, 0, 0, ul, "R8");
    // R2/R8: trip and undervoltage together
    run_case(8, 0, 0, 3, "R2");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule